// File: doc/BRIEF.md
# Timer Event Interrupt and Wakeup Collector

This block gathers the three event strobes of a general purpose timer (input capture, counter overflow and compare match) into a sticky status register. Each source has its own interrupt-enable bit and its own wakeup-enable bit. The block drives a level interrupt that stays high while any status bit is set. It also drives a one-cycle wakeup pulse that goes to the power-management logic.

Firmware programs the two enable registers and acknowledges events through a simple write port: a strobe, a register select and a data word. Acknowledging a capture event also sends a strobe to the capture unit, which restarts its capture count. A soft-reset input clears every enable and every status bit. The strobes come from the counter and capture units. One cycle after an event, its result is visible on the outputs.

Top module: `tmr_evt_irq`

## Requirements
- R1: Event input bit 2 is capture, bit 1 is overflow and bit 0 is compare match. Each maps to the status bit at the same position.
- R2: On the clock edge after an event, its status bit is set only if the matching interrupt-enable bit is 1. An event whose interrupt enable is 0 leaves the status unchanged.
- R3: `irq` is high whenever any status bit is set. It goes low in the cycle after the last set bit is cleared.
- R4: A write with `wr_sel` = 0 (status) clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R5: A wakeup pulse goes out on the clock edge after any event whose wakeup-enable bit is 1, whatever the interrupt enable. The pulse lasts exactly one cycle when the event strobe is one cycle long.
- R6: A status write whose data bit 2 is 1 raises `capt_clr` combinationally in the same cycle. No other write raises it.
- R7: A write with `wr_sel` = 1 loads the interrupt-enable register and `wr_sel` = 2 loads the wakeup-enable register. Each register is 3 bits wide and keeps data bits [2:0]; upper data bits are ignored. `wr_sel` = 3 has no effect.
- R8: If an enabled event and a clear of the same status bit happen in the same cycle, the bit stays set.
- R9: `soft_rst` clears both enable registers and the status register on the next edge and suppresses that cycle's wakeup pulse. Events in that cycle are not latched.
- R10: After `rst`, status, both enables, `irq` and `wake` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear of enables and status |
| evt | input | 3 | Event strobes: [2] capture, [1] overflow, [0] match |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 status clear, 1 interrupt enable, 2 wakeup enable, 3 unused |
| wr_data | input | 32 | Write data |
| irq | output | 1 | Level interrupt |
| wake | output | 1 | One-cycle wakeup pulse |
| capt_clr | output | 1 | Capture-count reset strobe |
| status | output | 3 | Status register |
| irq_en | output | 3 | Interrupt-enable register |
| wake_en | output | 3 | Wakeup-enable register |

## Verification
On every cycle, the assertions check the per-bit status rules: a disabled event never sets a bit, a written 1 clears a bit unless the same event arrives, and the event wins that collision. They also check that the wakeup pulse follows exactly the enabled events of the previous cycle and that `irq` only rises after an enabled event. The bench scenarios are what show the whole sequence through the register port. They cover the enable loads with upper bits set, the ignored select value, the wakeup firing while the interrupt is masked, `irq` staying high until the last bit is cleared, the capture-clear strobe and soft reset overriding pending events.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
    localparam int N_EVT  = 3;
    localparam int DATA_W = 32;

    localparam int BIT_MATCH = 0;
    localparam int BIT_OVF   = 1;
    localparam int BIT_CAPT  = 2;

    typedef logic [N_EVT-1:0] evt_vec_t;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_IRQ_EN = 2'd1,
        SEL_WAKE_EN = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     clr_st;
        logic     ld_ie;
        logic     ld_we;
        evt_vec_t bits;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_wr(input logic en, input reg_sel_e sel,
                                          input logic [DATA_W-1:0] data);
        wr_cmd_t c;
        c.clr_st = en && (sel == SEL_STATUS);
        c.ld_ie  = en && (sel == SEL_IRQ_EN);
        c.ld_we  = en && (sel == SEL_WAKE_EN);
        c.bits   = data[N_EVT-1:0];
        return c;
    endfunction
endpackage

// File: rtl/tmr_evt_enable.sv
module tmr_evt_enable
    import tmr_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     soft_rst,
    input  logic     load,
    input  evt_vec_t din,
    output evt_vec_t q
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) q <= '0;
        else if (load)       q <= din;
    end

    a_r7_load_value: assert property (@(posedge clk) disable iff (rst)
        (load && !soft_rst) |=> (q == $past(din)));
    a_r7_hold_value: assert property (@(posedge clk) disable iff (rst)
        (!load && !soft_rst) |=> $stable(q));
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
    import tmr_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     soft_rst,
    input  evt_vec_t evt,
    input  evt_vec_t ie,
    input  logic     clr,
    input  evt_vec_t clr_bits,
    output evt_vec_t st
);
    evt_vec_t st_nxt;

    always_comb begin
        st_nxt = st;
        if (clr) st_nxt = st_nxt & ~clr_bits;
        st_nxt = st_nxt | (evt & ie);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) st <= '0;
        else                 st <= st_nxt;
    end

    for (genvar i = 0; i < N_EVT; i++) begin : g_chk
        a_r2_masked_no_set: assert property (@(posedge clk) disable iff (rst)
            (!ie[i] && !st[i]) |=> !st[i]);
        a_r4_clear_bit: assert property (@(posedge clk) disable iff (rst)
            (clr && clr_bits[i] && !evt[i]) |=> !st[i]);
        a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
            (clr && clr_bits[i] && evt[i] && ie[i] && !soft_rst) |=> st[i]);
    end
endmodule

// File: rtl/tmr_evt_wake.sv
module tmr_evt_wake
    import tmr_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     soft_rst,
    input  evt_vec_t evt,
    input  evt_vec_t we,
    output logic     pulse
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) pulse <= 1'b0;
        else                 pulse <= |(evt & we);
    end

    a_r5_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        (|(evt & we) && !soft_rst) |=> pulse);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(|(evt & we)) |=> !pulse);
endmodule

// File: rtl/tmr_evt_irq.sv
module tmr_evt_irq
    import tmr_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic [2:0]        evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    output logic              irq,
    output logic              wake,
    output logic              capt_clr,
    output logic [2:0]        status,
    output logic [2:0]        irq_en,
    output logic [2:0]        wake_en
);
    wr_cmd_t cmd;
    assign cmd = decode_wr(wr_en, reg_sel_e'(wr_sel), wr_data);

    tmr_evt_enable u_ie (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .load(cmd.ld_ie), .din(cmd.bits), .q(irq_en)
    );

    tmr_evt_enable u_we (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .load(cmd.ld_we), .din(cmd.bits), .q(wake_en)
    );

    tmr_evt_status u_st (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .evt(evt), .ie(irq_en), .clr(cmd.clr_st), .clr_bits(cmd.bits),
        .st(status)
    );

    tmr_evt_wake u_wk (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .evt(evt), .we(wake_en), .pulse(wake)
    );

    assign irq      = |status;
    assign capt_clr = cmd.clr_st && cmd.bits[BIT_CAPT];

    a_r3_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(evt & irq_en)));
    a_r9_soft_clears: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (status == '0 && irq_en == '0 && wake_en == '0 && !wake));
    a_r6_capt_strobe_source: assert property (@(posedge clk) disable iff (rst)
        capt_clr |-> (wr_en && wr_sel == 2'd0));
endmodule

// File: tb/tb_tmr_evt_irq.sv
module tb_tmr_evt_irq;
    logic        clk = 0;
    logic        rst, soft_rst, wr_en;
    logic [2:0]  evt;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        irq, wake, capt_clr;
    logic [2:0]  status, irq_en, wake_en;

    always #5 clk = ~clk;

    tmr_evt_irq dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .evt(evt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq(irq), .wake(wake), .capt_clr(capt_clr),
        .status(status), .irq_en(irq_en), .wake_en(wake_en)
    );

    typedef struct {
        logic [2:0] st, ie, we;
        logic       irq, wake;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    logic [2:0] m_st = 0, m_ie = 0, m_we = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, predict the next-edge result and queue it.
    task automatic step(input logic wr, input logic [1:0] sel, input logic [31:0] d,
                        input logic [2:0] ev, input logic sr, input string tag);
        exp_t e;
        logic [2:0] clr;
        @(negedge clk);
        wr_en = wr; wr_sel = sel; wr_data = d; evt = ev; soft_rst = sr;
        #1;
        check({tag, " R6 capt_clr"}, capt_clr, wr && sel == 2'd0 && d[2]);
        clr = (wr && sel == 2'd0) ? d[2:0] : 3'b0;
        if (sr) begin
            e.wake = 0; m_st = 0; m_ie = 0; m_we = 0;
        end else begin
            e.wake = |(ev & m_we);
            m_st = (m_st & ~clr) | (ev & m_ie);
            if (wr && sel == 2'd1) m_ie = d[2:0];
            if (wr && sel == 2'd2) m_we = d[2:0];
        end
        e.st = m_st; e.ie = m_ie; e.we = m_we; e.irq = |m_st; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare after each edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " status"}, status, e.st);
            check({e.tag, " irq_en"}, irq_en, e.ie);
            check({e.tag, " wake_en"}, wake_en, e.we);
            check({e.tag, " irq"}, irq, e.irq);
            check({e.tag, " wake"}, wake, e.wake);
        end
    end

    task automatic idle(input string tag);
        step(0, 2'd0, 0, 3'b000, 0, tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; soft_rst = 0; wr_en = 0; wr_sel = 0; wr_data = 0; evt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check("R10 reset status", status, 0);
        check("R10 reset ie", irq_en, 0);
        check("R10 reset we", wake_en, 0);
        check("R10 reset irq", irq, 0);
        check("R10 reset wake", wake, 0);

        // R2: event while disabled does nothing
        step(0, 2'd0, 0, 3'b111, 0, "R2 masked events");
        // R7: upper bits ignored, select 3 ignored
        step(1, 2'd1, 32'hFFFF_FFF5, 3'b000, 0, "R7 ie load upper ignored");
        step(1, 2'd3, 32'h0000_0007, 3'b000, 0, "R7 sel3 no effect");
        step(1, 2'd2, 32'hA5A5_A5FA, 3'b000, 0, "R7 we load upper ignored");
        // R1: individual sources, ie=101 we=010
        step(0, 2'd0, 0, 3'b001, 0, "R1 match event");
        step(0, 2'd0, 0, 3'b100, 0, "R1 capture event");
        // R5: overflow masked for irq but wakes
        step(0, 2'd0, 0, 3'b010, 0, "R5 overflow wake masked irq");
        idle("R5 wake one cycle");
        // R4: clear only bit 0, bit 2 stays, irq stays
        step(1, 2'd0, 32'h0000_0001, 3'b000, 0, "R4 clear bit0");
        // R8: capture event with capture clear same cycle (also R6)
        step(1, 2'd0, 32'h0000_0004, 3'b100, 0, "R8 event wins");
        // R3: last bit cleared drops irq
        step(1, 2'd0, 32'hFFFF_FFFC, 3'b000, 0, "R3 clear last bit");
        idle("R3 irq low");
        // all enables, back-to-back events
        step(1, 2'd1, 32'h7, 3'b000, 0, "R7 ie all");
        step(1, 2'd2, 32'h7, 3'b000, 0, "R7 we all");
        step(0, 2'd0, 0, 3'b011, 0, "R1 ovf+match");
        step(1, 2'd0, 32'h0000_0002, 3'b000, 0, "R4 clear ovf only");
        // R9: soft reset beats event
        step(0, 2'd0, 0, 3'b111, 1, "R9 soft reset");
        step(0, 2'd0, 0, 3'b111, 0, "R9 after soft no enables");
        idle("R9 idle");
        idle("final");
        @(negedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule